// File: doc/BRIEF.md
# Remote Sensor Fault Screening Logic

This block sits between a remote temperature converter and the register that holds the remote reading. Each time the converter signals the end of a conversion, the block samples the raw reading and the open-circuit and short-circuit flags reported by the sensor front end. If no flag is set, the reading is stored. It is then compared against a high limit, a low limit and an over-temperature threshold, and a one-cycle event pulse is produced for each limit that is crossed. An interrupt request pulse is produced for each event whose mask is clear.

If any fault flag is set at the strobe, the stored value becomes a fixed sentinel code, which is the most negative two's-complement value (0x80 for 8 bits). A fault event is raised, and every limit and over-temperature indication derived from the remote channel is suppressed for that conversion.

The over-temperature line is active-low and open-drain. It is modelled as a pull-down enable plus a readback of the wired level. A valid local over-temperature condition, or any other device pulling the line low, still activates it while the remote channel is faulted.

Top module: `rsense_screen`

## Requirements
- R1: After reset the stored value is 0x00, the event pulses `hi_evt`, `lo_evt`, `fault_evt` and the interrupt request `irq` are 0, and `therm_oe` is 0.
- R2: On a conversion strobe with all fault flags clear, the stored value equals the raw reading from the next clock edge onward.
- R3: On a clean conversion, `hi_evt` pulses for exactly one cycle if the reading is greater than the high limit under signed comparison. A reading equal to the high limit raises no event.
- R4: On a clean conversion, `lo_evt` pulses for exactly one cycle if the reading is less than the low limit under signed comparison. For example, 0xEC (-20) is below 10.
- R5: On a conversion strobe with any fault flag set, the stored value becomes 0x80 and `fault_evt` pulses for one cycle.
- R6: A faulted conversion raises neither `hi_evt` nor `lo_evt`, whatever the reading, and clears the remote over-temperature state.
- R7: A clean conversion whose reading is greater than or equal to the over-temperature limit makes `therm_oe` 1. It holds until the next conversion whose reading is below that limit, or which is faulted.
- R8: While `local_over` is 1, `therm_oe` is 1, even when the remote channel is faulted.
- R9: `therm_seen` is 1 whenever the wired line `therm_line_n` reads low. This includes the case where the line is pulled low by another device while `therm_oe` is 0.
- R10: `irq` pulses with each event whose mask input is 0. A mask input of 1 blocks that source from `irq`, but its event pulse still appears.
- R11: Without a strobe, changes on the raw reading or the fault flags leave the stored value unchanged. A value of 0x80 left by a fault stays until the next clean conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | End-of-conversion strobe, one cycle |
| raw_temp | input | 8 | Raw two's-complement reading |
| fault_flags | input | 2 | Sensor fault flags: bit 0 open, bit 1 short |
| hi_limit | input | 8 | High limit, signed |
| lo_limit | input | 8 | Low limit, signed |
| therm_limit | input | 8 | Over-temperature threshold, signed |
| mask_hi | input | 1 | 1 blocks the high-limit source from irq |
| mask_lo | input | 1 | 1 blocks the low-limit source from irq |
| mask_fault | input | 1 | 1 blocks the fault source from irq |
| local_over | input | 1 | Valid local over-temperature condition |
| therm_line_n | input | 1 | Readback of the wired over-temperature line |
| remote_temp | output | 8 | Stored remote value |
| hi_evt | output | 1 | High-limit event pulse |
| lo_evt | output | 1 | Low-limit event pulse |
| fault_evt | output | 1 | Sensor fault event pulse |
| irq | output | 1 | Unmasked interrupt request pulse |
| therm_oe | output | 1 | Pull-down enable for the wired line |
| therm_seen | output | 1 | Wired line observed active |

## Verification
The hardest state to reach is a faulted conversion whose raw reading would otherwise trip the high limit and the over-temperature threshold, arriving while the remote over-temperature state is already set.

The stimulus first runs a clean hot conversion so that `therm_oe` is held. It then strobes a fault with a reading of 100. This shows that the sentinel is stored, that no limit event appears and that the pull-down releases. `local_over` and an external pull are then applied during the fault to show that these sources still work.

// File: rtl/rsense_pkg.sv
package rsense_pkg;
   typedef struct packed {
      logic hi;
      logic lo;
      logic fault;
   } rs_evt_t;

   localparam int unsigned RS_DEF_TEMP_W  = 8;
   localparam int unsigned RS_DEF_N_FAULT = 2;
endpackage

// File: rtl/rs_capture.sv
module rs_capture #(
   parameter int unsigned TEMP_W  = 8,
   parameter int unsigned N_FAULT = 2,
   parameter logic [TEMP_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [TEMP_W-1:0] raw_temp,
   input  logic [N_FAULT-1:0] fault_flags,
   output logic              fault_any,
   output logic [TEMP_W-1:0] temp_q
);
   localparam logic [TEMP_W-1:0] SENTINEL = {1'b1, {(TEMP_W-1){1'b0}}};

   generate
      if (N_FAULT < 1) begin : g_bad_fault
         $error("rs_capture: N_FAULT must be at least 1");
      end
   endgenerate

   assign fault_any = |fault_flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_q <= RESET_VAL;
      end else if (conv_done) begin
         temp_q <= fault_any ? SENTINEL : raw_temp;
      end
   end

   assert_fault_sentinel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && fault_any) |=> (temp_q == SENTINEL));

   assert_clean_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !fault_any) |=> (temp_q == $past(raw_temp)));

   assert_hold_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(temp_q));
endmodule

// File: rtl/rs_limit_check.sv
module rs_limit_check #(
   parameter int unsigned TEMP_W     = 8,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic [TEMP_W-1:0] value,
   input  logic [TEMP_W-1:0] hi_limit,
   input  logic [TEMP_W-1:0] lo_limit,
   input  logic [TEMP_W-1:0] therm_limit,
   output logic              over_hi,
   output logic              under_lo,
   output logic              at_therm
);
   generate
      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            over_hi  = $signed(value) >  $signed(hi_limit);
            under_lo = $signed(value) <  $signed(lo_limit);
            at_therm = $signed(value) >= $signed(therm_limit);
         end
      end else begin : g_unsigned
         always_comb begin
            over_hi  = value >  hi_limit;
            under_lo = value <  lo_limit;
            at_therm = value >= therm_limit;
         end
      end
   endgenerate
endmodule

// File: rtl/rs_event_reg.sv
module rs_event_reg
   import rsense_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic conv_done,
   input  logic fault_any,
   input  logic over_hi,
   input  logic under_lo,
   input  logic at_therm,
   input  logic mask_hi,
   input  logic mask_lo,
   input  logic mask_fault,
   output rs_evt_t evt_q,
   output logic irq,
   output logic remote_hot
);
   rs_evt_t evt_d;
   logic    irq_d;

   always_comb begin
      evt_d.hi    = conv_done && !fault_any && over_hi;
      evt_d.lo    = conv_done && !fault_any && under_lo;
      evt_d.fault = conv_done && fault_any;
      irq_d = (evt_d.hi && !mask_hi) || (evt_d.lo && !mask_lo) ||
              (evt_d.fault && !mask_fault);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q      <= '0;
         irq        <= 1'b0;
         remote_hot <= 1'b0;
      end else begin
         evt_q <= evt_d;
         irq   <= irq_d;
         if (conv_done) begin
            remote_hot <= !fault_any && at_therm;
         end
      end
   end

   assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && fault_any) |=> (!evt_q.hi && !evt_q.lo && !remote_hot));

   assert_hi_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.hi |-> $past(conv_done));

   assert_lo_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.lo |-> $past(conv_done));

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_q.hi || evt_q.lo || evt_q.fault));
endmodule

// File: rtl/rsense_screen.sv
module rsense_screen
   import rsense_pkg::*;
#(
   parameter int unsigned TEMP_W     = RS_DEF_TEMP_W,
   parameter int unsigned N_FAULT    = RS_DEF_N_FAULT,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [TEMP_W-1:0] raw_temp,
   input  logic [N_FAULT-1:0] fault_flags,
   input  logic [TEMP_W-1:0] hi_limit,
   input  logic [TEMP_W-1:0] lo_limit,
   input  logic [TEMP_W-1:0] therm_limit,
   input  logic              mask_hi,
   input  logic              mask_lo,
   input  logic              mask_fault,
   input  logic              local_over,
   input  logic              therm_line_n,
   output logic [TEMP_W-1:0] remote_temp,
   output logic              hi_evt,
   output logic              lo_evt,
   output logic              fault_evt,
   output logic              irq,
   output logic              therm_oe,
   output logic              therm_seen
);
   generate
      if (TEMP_W < 2) begin : g_bad_width
         $error("rsense_screen: TEMP_W must be at least 2");
      end
   endgenerate

   logic    fault_any;
   logic    over_hi, under_lo, at_therm;
   logic    remote_hot;
   rs_evt_t evt_q;

   rs_capture #(
      .TEMP_W (TEMP_W),
      .N_FAULT(N_FAULT)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_done  (conv_done),
      .raw_temp   (raw_temp),
      .fault_flags(fault_flags),
      .fault_any  (fault_any),
      .temp_q     (remote_temp)
   );

   rs_limit_check #(
      .TEMP_W    (TEMP_W),
      .SIGNED_CMP(SIGNED_CMP)
   ) i_limits (
      .value      (raw_temp),
      .hi_limit   (hi_limit),
      .lo_limit   (lo_limit),
      .therm_limit(therm_limit),
      .over_hi    (over_hi),
      .under_lo   (under_lo),
      .at_therm   (at_therm)
   );

   rs_event_reg i_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_done (conv_done),
      .fault_any (fault_any),
      .over_hi   (over_hi),
      .under_lo  (under_lo),
      .at_therm  (at_therm),
      .mask_hi   (mask_hi),
      .mask_lo   (mask_lo),
      .mask_fault(mask_fault),
      .evt_q     (evt_q),
      .irq       (irq),
      .remote_hot(remote_hot)
   );

   assign hi_evt     = evt_q.hi;
   assign lo_evt     = evt_q.lo;
   assign fault_evt  = evt_q.fault;
   assign therm_oe   = remote_hot | local_over;
   assign therm_seen = ~therm_line_n;

   assert_local_therm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      local_over |-> therm_oe);

   assert_evt_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |-> (!hi_evt && !lo_evt));
endmodule

// File: tb/test_rsense_screen.sv
`timescale 1ns/1ps
module test_rsense_screen;
   typedef struct packed {
      logic [7:0] temp;
      logic       hi;
      logic       lo;
      logic       fault;
      logic       irq;
      logic       hot;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_done = 1'b0;
   logic [7:0] raw_temp = '0;
   logic [1:0] fault_flags = '0;
   logic [7:0] hi_limit = 8'd60, lo_limit = 8'd10, therm_limit = 8'd80;
   logic       mask_hi = 0, mask_lo = 0, mask_fault = 0;
   logic       local_over = 0;
   logic       ext_pull = 0;
   logic       therm_line_n;
   logic [7:0] remote_temp;
   logic       hi_evt, lo_evt, fault_evt, irq, therm_oe, therm_seen;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   logic model_hot = 1'b0;

   always #2.5 clk = ~clk;

   assign therm_line_n = ~(therm_oe | ext_pull);

   rsense_screen i_rsense_screen (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .raw_temp(raw_temp),
      .fault_flags(fault_flags), .hi_limit(hi_limit), .lo_limit(lo_limit),
      .therm_limit(therm_limit), .mask_hi(mask_hi), .mask_lo(mask_lo),
      .mask_fault(mask_fault), .local_over(local_over), .therm_line_n(therm_line_n),
      .remote_temp(remote_temp), .hi_evt(hi_evt), .lo_evt(lo_evt),
      .fault_evt(fault_evt), .irq(irq), .therm_oe(therm_oe), .therm_seen(therm_seen)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // driver: computes expectation from the requirements and queues it
   task automatic convert(input logic [7:0] raw, input logic [1:0] flg);
      exp_t e;
      logic f;
      f = |flg;
      e.temp  = f ? 8'h80 : raw;
      e.hi    = !f && ($signed(raw) > $signed(hi_limit));
      e.lo    = !f && ($signed(raw) < $signed(lo_limit));
      e.fault = f;
      e.irq   = (e.hi && !mask_hi) || (e.lo && !mask_lo) || (e.fault && !mask_fault);
      e.hot   = !f && ($signed(raw) >= $signed(therm_limit));
      @(negedge clk);
      raw_temp = raw;
      fault_flags = flg;
      conv_done = 1'b1;
      q.push_back(e);
      @(negedge clk);
      conv_done = 1'b0;
      @(negedge clk);
      check("R3 hi pulse one cycle", hi_evt, 0);
      check("R4 lo pulse one cycle", lo_evt, 0);
      check("R5 fault pulse one cycle", fault_evt, 0);
   endtask

   // monitor: after each strobe edge, pop and compare
   always @(posedge clk) begin
      if (rst_n && conv_done) begin
         #1;
         if (q.size() == 0) begin
            check("monitor queue", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            model_hot = e.hot;
            check(e.fault ? "R5 sentinel" : "R2 stored value", remote_temp, e.temp);
            check(e.fault ? "R6 no hi on fault" : "R3 hi_evt", hi_evt, e.hi);
            check(e.fault ? "R6 no lo on fault" : "R4 lo_evt", lo_evt, e.lo);
            check("R5 fault_evt", fault_evt, e.fault);
            check("R10 irq", irq, e.irq);
            check("R7 therm_oe", therm_oe, e.hot | local_over);
         end
      end
   end

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1;
      check("R1 reset value", remote_temp, 8'h00);
      check("R1 reset events", {hi_evt, lo_evt, fault_evt, irq}, 4'b0);
      check("R1 reset therm_oe", therm_oe, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 after release", remote_temp, 8'h00);

      convert(8'd25, 2'b00);                 // R2 in range
      convert(8'd70, 2'b00);                 // R3 above high
      convert(8'd60, 2'b00);                 // R3 equal, no event
      convert(8'hEC, 2'b00);                 // R4 -20 below 10
      convert(8'd80, 2'b00);                 // R7 equal to threshold
      repeat (4) @(negedge clk);
      check("R7 therm_oe held", therm_oe, 1);
      check("R9 therm_seen from own drive", therm_seen, 1);
      convert(8'd100, 2'b01);                // R5 R6 open fault, hot reading
      check("R7 therm released by fault", therm_oe, 0);
      @(negedge clk);
      fault_flags = 2'b00;
      raw_temp = 8'd33;
      repeat (3) @(negedge clk);
      check("R11 sentinel kept without strobe", remote_temp, 8'h80);
      local_over = 1'b1;
      #0.1;
      check("R8 local over during fault", therm_oe, 1);
      convert(8'd5, 2'b10);                  // short fault with local active
      check("R8 local still drives", therm_oe, 1);
      local_over = 1'b0;
      ext_pull = 1'b1;
      #0.1;
      check("R9 external pull seen", therm_seen, 1);
      check("R9 own drive off", therm_oe, 0);
      ext_pull = 1'b0;
      #0.1;
      check("R9 line idle", therm_seen, 0);
      mask_hi = 1'b1;
      convert(8'd90, 2'b00);                 // R10 masked hi, R7 hot
      mask_hi = 1'b0;
      mask_fault = 1'b1;
      convert(8'd40, 2'b11);                 // R10 masked fault
      mask_fault = 1'b0;
      mask_lo = 1'b1;
      convert(8'h80, 2'b00);                 // R4 most negative, masked
      mask_lo = 1'b0;
      convert(8'd45, 2'b00);                 // R11 clean conversion restores
      check("R11 restored value", remote_temp, 8'd45);
      raw_temp = 8'd77;
      fault_flags = 2'b01;
      repeat (3) @(negedge clk);
      check("R11 flags ignored without strobe", remote_temp, 8'd45);
      check("R11 no fault event without strobe", fault_evt, 0);
      fault_flags = 2'b00;
      repeat (2) @(negedge clk);
      check("queue drained", q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule